// File: doc/BRIEF.md
# Scan Child Vector Flip Generator

This block sits on the serial input of a scan chain during self-test. A parent vector arrives one bit per shift cycle. The block passes that bit through or complements it, and so derives "child" vectors that lie at a controlled random Hamming distance from the parent. Each bit is complemented independently with probability 2^-n. The flip signal is the AND of n bits taken from a 32-bit linear feedback shift register, so every flip probability is a power of two.

A built-in sequencer counts shift cycles and runs a fixed schedule for each phase, with one parent per phase. The first vector of a phase is the unmodified parent. After it come a configurable number of children of type A, then the same number of type B. Type A defaults to probability 1/4 and type B to 1/2. When the last phase ends, the block stays in a terminal state and passes data through unchanged until it is reset. The current vector kind and phase index are visible at the ports, so the surrounding test controller can follow the schedule.

Top module: `star_child_gen`

## Requirements
- R1: On synchronous reset, `child_bit` is 0, `kind` is 0, `phase` is 0 and `child_en` is 0, and the random source is loaded with the nonzero parameter `SEED`.
- R2: While `shift_en` is low, `child_bit`, `kind`, `phase` and the random source all keep their values.
- R3: During a parent vector (`kind` = 0), `child_bit` equals the `parent_bit` value that was presented at the previous shift edge.
- R4: The random source is a 32-bit Fibonacci LFSR that shifts toward the MSB. Its new bit 0 is s[31]^s[21]^s[1]^s[0]. It steps exactly once per cycle with `shift_en` high, in every state.
- R5: During a child vector, the flip bit is the AND of LFSR bits 0, 6, 12, ... (the first n of them), taken before the step. `child_bit` becomes `parent_bit` XOR flip at that shift edge.
- R6: Type A vectors use n = `WIDTH_A` (default 2, probability 1/4). Type B vectors use n = `WIDTH_B` (default 1, probability 1/2).
- R7: Each vector lasts `CHAIN_LEN` shift cycles. A phase consists of one parent vector, then `CHILDREN_PER_TYPE` type A vectors, then `CHILDREN_PER_TYPE` type B vectors. Phases are numbered 0 to `NUM_PHASES`-1, and each new phase starts with a parent vector.
- R8: After the last vector of the last phase, `kind` is 3 and stays there until reset. In that state, data passes through unchanged.
- R9: `kind` encodes the current vector: 0 parent, 1 type A, 2 type B, 3 finished.
- R10: `child_en` is high exactly while `kind` is 1 or 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Scan shift cycle qualifier |
| parent_bit | input | 1 | Incoming parent scan bit |
| child_bit | output | 1 | Registered, possibly complemented scan bit |
| child_en | output | 1 | High while a child vector is being shifted |
| kind | output | 2 | Current vector kind (see R9) |
| phase | output | PH_W | Current phase index |

## Verification
`child_bit` is registered. It reflects the input and flip decision of the shift edge just passed, so the bench samples it at the falling edge after each rising edge. `kind`, `phase` and `child_en` come straight from sequencer state. The bench compares them at the falling edge before driving the next cycle, because they describe the bit about to be shifted. The bench keeps its own LFSR and schedule counters, computed from R4 to R7, and steps them only on cycles where it raised `shift_en`. A small configuration lets the sweep cover every vector of every phase, the terminal state, and idle gaps spread through the run.

// File: rtl/star_pkg.sv
package star_pkg;

    localparam int LFSR_W     = 32;
    localparam int TAP_STRIDE = 6;
    localparam int MAX_AND    = 5;

    typedef enum logic [1:0] {
        KIND_PARENT = 2'd0,
        KIND_A      = 2'd1,
        KIND_B      = 2'd2,
        KIND_DONE   = 2'd3
    } kind_t;

    // Fibonacci step, feedback from bits 31, 21, 1, 0
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic fb;
        fb = s[31] ^ s[21] ^ s[1] ^ s[0];
        return {s[LFSR_W-2:0], fb};
    endfunction

endpackage

// File: rtl/star_lfsr.sv
module star_lfsr
    import star_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [LFSR_W-1:0] state
);

    always_ff @(posedge clk) begin
        if (rst)      state <= SEED;
        else if (adv) state <= lfsr_step(state);
    end

endmodule

// File: rtl/star_sequencer.sv
module star_sequencer
    import star_pkg::*;
#(
    parameter int CHAIN_LEN         = 64,
    parameter int CHILDREN_PER_TYPE = 2048,
    parameter int NUM_PHASES        = 4,
    localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
    localparam int VEC_W = (CHILDREN_PER_TYPE > 1) ? $clog2(CHILDREN_PER_TYPE) : 1,
    localparam int PH_W  = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            adv,
    output kind_t           kind,
    output logic [PH_W-1:0] phase
);

    logic [BIT_W-1:0] bit_q;
    logic [VEC_W-1:0] vec_q;
    logic             last_bit;
    logic             last_vec;
    logic             last_phase;

    assign last_bit   = (bit_q == BIT_W'(CHAIN_LEN - 1));
    assign last_vec   = (vec_q == VEC_W'(CHILDREN_PER_TYPE - 1));
    assign last_phase = (phase == PH_W'(NUM_PHASES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= '0;
            vec_q <= '0;
            kind  <= KIND_PARENT;
            phase <= '0;
        end else if (adv && kind != KIND_DONE) begin
            if (!last_bit) begin
                bit_q <= bit_q + 1'b1;
            end else begin
                bit_q <= '0;
                case (kind)
                    KIND_PARENT: begin
                        kind  <= KIND_A;
                        vec_q <= '0;
                    end
                    KIND_A: begin
                        if (last_vec) begin
                            kind  <= KIND_B;
                            vec_q <= '0;
                        end else begin
                            vec_q <= vec_q + 1'b1;
                        end
                    end
                    KIND_B: begin
                        if (last_vec) begin
                            vec_q <= '0;
                            if (last_phase) begin
                                kind <= KIND_DONE;
                            end else begin
                                phase <= phase + 1'b1;
                                kind  <= KIND_PARENT;
                            end
                        end else begin
                            vec_q <= vec_q + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/star_flip.sv
module star_flip
    import star_pkg::*;
#(
    parameter int WIDTH_A = 2,
    parameter int WIDTH_B = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  kind_t             kind,
    input  logic [LFSR_W-1:0] rnd,
    input  logic              din,
    output logic              dout
);

    // prefix AND over spaced LFSR taps; pre[n] is the AND of the first n taps
    logic [MAX_AND:0] pre;
    assign pre[0] = 1'b1;

    genvar g;
    generate
        for (g = 0; g < MAX_AND; g++) begin : g_tap
            assign pre[g+1] = pre[g] & rnd[g*TAP_STRIDE];
        end
    endgenerate

    logic flip;
    always_comb begin
        case (kind)
            KIND_A:  flip = pre[WIDTH_A];
            KIND_B:  flip = pre[WIDTH_B];
            default: flip = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)           dout <= 1'b0;
        else if (shift_en) dout <= din ^ flip;
    end

endmodule

// File: rtl/star_child_gen.sv
module star_child_gen
    import star_pkg::*;
#(
    parameter int                CHAIN_LEN         = 64,
    parameter int                CHILDREN_PER_TYPE = 2048,
    parameter int                NUM_PHASES        = 4,
    parameter int                WIDTH_A           = 2,
    parameter int                WIDTH_B           = 1,
    parameter logic [LFSR_W-1:0] SEED              = 32'hACE1_2468,
    localparam int PH_W = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            parent_bit,
    output logic            child_bit,
    output logic            child_en,
    output logic [1:0]      kind,
    output logic [PH_W-1:0] phase
);

    logic [LFSR_W-1:0] lfsr_state;
    kind_t             kind_s;

    star_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (shift_en),
        .state (lfsr_state)
    );

    star_sequencer #(
        .CHAIN_LEN         (CHAIN_LEN),
        .CHILDREN_PER_TYPE (CHILDREN_PER_TYPE),
        .NUM_PHASES        (NUM_PHASES)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .adv   (shift_en),
        .kind  (kind_s),
        .phase (phase)
    );

    star_flip #(.WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B)) u_flip (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .kind     (kind_s),
        .rnd      (lfsr_state),
        .din      (parent_bit),
        .dout     (child_bit)
    );

    assign kind     = kind_s;
    assign child_en = (kind_s == KIND_A) || (kind_s == KIND_B);

endmodule

// File: rtl/star_child_gen_chk.sv
module star_child_gen_chk #(
    parameter int PH_W = 1
) (
    input logic            clk,
    input logic            rst,
    input logic            shift_en,
    input logic            parent_bit,
    input logic            child_bit,
    input logic            child_en,
    input logic [1:0]      kind,
    input logic [PH_W-1:0] phase,
    input logic [31:0]     lfsr_state
);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(child_bit) && $stable(kind) && $stable(phase) && $stable(lfsr_state));

    assert_parent_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (shift_en && kind == 2'd0) |=> child_bit == $past(parent_bit));

    assert_lfsr_moves_R4: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> lfsr_state != $past(lfsr_state));

    assert_lfsr_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 32'd0);

    assert_no_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (shift_en && child_en && !lfsr_state[0]) |=> child_bit == $past(parent_bit));

    assert_phase_starts_parent_R7: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> kind == 2'd0);

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        kind == 2'd3 |=> kind == 2'd3);

    assert_done_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (shift_en && kind == 2'd3) |=> child_bit == $past(parent_bit));

endmodule

bind star_child_gen star_child_gen_chk #(.PH_W(PH_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .parent_bit (parent_bit),
    .child_bit  (child_bit),
    .child_en   (child_en),
    .kind       (kind),
    .phase      (phase),
    .lfsr_state (lfsr_state)
);

// File: tb/test_star_child_gen.sv
`timescale 1ns/1ps
module test_star_child_gen;

    localparam int          CL   = 5;
    localparam int          NCH  = 3;
    localparam int          NPH  = 2;
    localparam int          WA   = 2;
    localparam int          WB   = 1;
    localparam logic [31:0] SEED = 32'hACE1_2468;
    localparam int          PW   = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          shift_en = 1'b0;
    logic          parent_bit = 1'b0;
    logic          child_bit;
    logic          child_en;
    logic [1:0]    kind;
    logic [PW-1:0] phase;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    star_child_gen #(
        .CHAIN_LEN(CL), .CHILDREN_PER_TYPE(NCH), .NUM_PHASES(NPH),
        .WIDTH_A(WA), .WIDTH_B(WB), .SEED(SEED)
    ) i_star_child_gen (
        .clk(clk), .rst(rst), .shift_en(shift_en), .parent_bit(parent_bit),
        .child_bit(child_bit), .child_en(child_en), .kind(kind), .phase(phase)
    );

    // independent model
    logic [31:0] m_lfsr;
    int          m_bit, m_vec, m_kind, m_phase;
    logic        m_dout;

    task automatic model_reset();
        m_lfsr = SEED; m_bit = 0; m_vec = 0; m_kind = 0; m_phase = 0; m_dout = 1'b0;
    endtask

    function automatic logic and_taps(logic [31:0] s, int n);
        logic a = 1'b1;
        for (int k = 0; k < n; k++) a = a & s[k*6];
        return a;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cycle(input logic se, input logic d);
        string tag;
        logic  flip;
        shift_en   = se;
        parent_bit = d;
        check("R7,R9 kind", int'(kind), m_kind);
        check("R7 phase", int'(phase), m_phase);
        check("R10 child_en", int'(child_en), (m_kind == 1 || m_kind == 2) ? 1 : 0);
        if (!se)                tag = "R2 hold";
        else if (m_kind == 3)   tag = "R8 done pass";
        else if (m_kind == 0)   tag = "R3 parent pass";
        else                    tag = "R4,R5,R6 child flip";
        if (se) begin
            flip = 1'b0;
            if (m_kind == 1) flip = and_taps(m_lfsr, WA);
            if (m_kind == 2) flip = and_taps(m_lfsr, WB);
            m_dout = d ^ flip;
            m_lfsr = {m_lfsr[30:0], m_lfsr[31] ^ m_lfsr[21] ^ m_lfsr[1] ^ m_lfsr[0]};
            if (m_kind != 3) begin
                if (m_bit < CL - 1) m_bit++;
                else begin
                    m_bit = 0;
                    if (m_kind == 0) begin m_kind = 1; m_vec = 0; end
                    else if (m_vec < NCH - 1) m_vec++;
                    else if (m_kind == 1) begin m_kind = 2; m_vec = 0; end
                    else begin
                        m_vec = 0;
                        if (m_phase == NPH - 1) m_kind = 3;
                        else begin m_phase++; m_kind = 0; end
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, int'(child_bit), int'(m_dout));
    endtask

    task automatic do_reset();
        rst = 1'b1; shift_en = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst = 1'b0;
        model_reset();
        check("R1 child_bit", int'(child_bit), 0);
        check("R1 kind", int'(kind), 0);
        check("R1 phase", int'(phase), 0);
        check("R1 child_en", int'(child_en), 0);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // full schedule with idle gaps; R1 seed observed through the first flips
        for (int i = 0; i < 220; i++) begin
            logic d;
            d = ^((i * 13) & 8'hB5) ^ i[3];
            cycle((i % 7) != 3, d);
        end
        check("R8 finished kind", int'(kind), 3);
        // restart mid-run after a second reset
        for (int i = 0; i < 17; i++) cycle(1'b1, i[0] ^ i[2]);
        do_reset();
        for (int i = 0; i < 60; i++) cycle((i % 5) != 0, ~i[1]);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule